// File: doc/BRIEF.md
# Memory Byte-Parity Protection Unit

This unit sits between a memory controller's request logic and an SRAM data bus. On the way out, it attaches an even-parity bit to every byte of write data, with one register stage. On the way back, it checks read data against the returned parity bits and hands the read on as a completion one cycle later. The read phase of an atomic read-modify-write is checked the same way as any other read. Checking is active only while a control bit is set. Parity generation never stops.

When checking finds a bad byte lane, the unit does three things. It sets a sticky error bit for that lane. It records the failing address, unless an earlier error is still pending. It raises the completion's data-error flag. The error bits drive two interrupt outputs, a normal one and a fast one, and each output has its own enable. A command may carry an ignore token that keeps the completion flag low, but the error is still logged. When a flagged completion belongs to a read issued by a processing engine, its signal number is replaced with the null code 0.

Top module: `mem_parity_guard`

## Requirements
- R1: Byte lane i is bits [8i+7:8i] of a data word, and its parity bit is bit i of the 4-bit parity field. Parity is even: each lane together with its parity bit holds an even count of ones.
- R1 (timing): A write accepted on `wr_valid` appears on `sram_we`/`sram_addr`/`sram_wdata`/`sram_wpar` one clock later.
- R2: Write parity is produced the same way whether checking is enabled or disabled.
- R3: While control bit 0 (check enable) is 0, a read never sets an error bit and never raises `cpl_err`, whatever parity it carries.
- R4: While checking is enabled, every lane whose parity disagrees sets its error bit at the edge that accepts the read. `cpl_err` rises with `cpl_valid` on the following cycle. A read with correct parity raises neither.
- R5: A read marked `rd_rmw` is checked exactly like a plain read, and the mark is passed on as `cpl_rmw`.
- R6: The error address register (register select 2) loads the read address only when an error arrives while no error bit would remain set after this cycle's clear. Otherwise it holds.
- R7: The error bits (register select 1, bits [3:0]) are sticky. Writing 1 to a bit clears it, and writing 0 leaves it as it is. A new error in the same cycle wins over a clear. All registers read 0 after reset.
- R8: `irq` is high while any error bit is set and control bit 1 is 1. `fiq` is high while any error bit is set and control bit 2 is 1.
- R9: A read with `rd_ign_err` set never raises `cpl_err`, but its error bits and address are logged as usual.
- R10: `cpl_sig` is 0 when `cpl_err` is high for a read with `rd_from_eng` set. In every other case it equals the read's `rd_sig`.
- R11: Every read returns exactly one completion, one clock later, with `cpl_data` equal to `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request valid |
| wr_addr | input | 20 | Write address |
| wr_data | input | 32 | Write data |
| sram_we | output | 1 | Registered write strobe to SRAM |
| sram_addr | output | 20 | Registered write address |
| sram_wdata | output | 32 | Registered write data |
| sram_wpar | output | 4 | Even parity, one bit per byte lane |
| rd_valid | input | 1 | Read data returned from SRAM |
| rd_addr | input | 20 | Address of the returned read |
| rd_data | input | 32 | Returned read data |
| rd_par | input | 4 | Returned parity bits |
| rd_rmw | input | 1 | Read is the first phase of an atomic read-modify-write |
| rd_ign_err | input | 1 | Command asked not to flag data errors |
| rd_from_eng | input | 1 | Read was issued by a processing engine |
| rd_sig | input | 4 | Completion signal number requested |
| cpl_valid | output | 1 | Read completion valid |
| cpl_data | output | 32 | Completion data |
| cpl_rmw | output | 1 | Completion belongs to an atomic read phase |
| cpl_err | output | 1 | Data-error flag |
| cpl_sig | output | 4 | Signal number, 0 when suppressed |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 2 | Register select: 0 control, 1 error bits, 2 error address |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data (combinational on `csr_sel`) |
| irq | output | 1 | Normal interrupt request |
| fiq | output | 1 | Fast interrupt request |

## Verification
The bench goes after the following corner cases:

- **Bad parity while checking is off.** A unit that ignores the enable would log phantom errors here.
- **A second error while the first is pending.** A unit that overwrites the captured address would report the wrong location.
- **A partial clear of the error bits.** A unit that clears every bit on any write would drop pending lanes.
- **The ignore token.** A unit that also skips logging would hide the fault.
- **A flagged read from a non-engine requester.** A unit that nulls every flagged completion would corrupt that requester's signal number.

Alongside these directed cases, random single-bit flips per lane are mixed with random enables and clears.

// File: rtl/mpg_pkg.sv
package mpg_pkg;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned CTRL_CHK = 0;
  localparam int unsigned CTRL_IRQ = 1;
  localparam int unsigned CTRL_FIQ = 2;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_ADDR = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  // even parity for one lane: XOR of all its bits
  function automatic logic lane_parity(input logic [LANE_W-1:0] b);
    return ^b;
  endfunction
endpackage

// File: rtl/mpg_wr_gen.sv
module mpg_wr_gen
  import mpg_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 20,
  localparam int unsigned LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              we_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q,
  output logic [LANES-1:0]  par_q
);
  logic [LANES-1:0] par_d;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign par_d[i] = lane_parity(wr_data[i*LANE_W +: LANE_W]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      par_q  <= '0;
    end else begin
      we_q <= wr_valid;
      if (wr_valid) begin
        addr_q <= wr_addr;
        data_q <= wr_data;
        par_q  <= par_d;
      end
    end
  end
endmodule

// File: rtl/mpg_rd_chk.sv
module mpg_rd_chk
  import mpg_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES = DATA_W / LANE_W
) (
  input  logic              valid,
  input  logic              chk_en,
  input  logic [DATA_W-1:0] data,
  input  logic [LANES-1:0]  par,
  output logic [LANES-1:0]  bad_lanes
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign bad_lanes[i] = valid && chk_en &&
                          (lane_parity(data[i*LANE_W +: LANE_W]) != par[i]);
  end
endmodule

// File: rtl/mpg_err_log.sv
module mpg_err_log #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANES-1:0]  set_lanes,
  input  logic [ADDR_W-1:0] set_addr,
  input  logic [LANES-1:0]  clr_mask,
  output logic [LANES-1:0]  err_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              cap_evt
);
  logic [LANES-1:0] kept;

  assign kept    = err_q & ~clr_mask;
  assign cap_evt = (set_lanes != '0) && (kept == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= '0;
      addr_q <= '0;
    end else begin
      err_q <= kept | set_lanes;
      if (cap_evt) addr_q <= set_addr;
    end
  end
endmodule

// File: rtl/mem_parity_guard.sv
module mem_parity_guard
  import mpg_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned SIG_W  = 4,
  parameter int unsigned CSR_W  = 32,
  localparam int unsigned LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              sram_we,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_wdata,
  output logic [LANES-1:0]  sram_wpar,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [LANES-1:0]  rd_par,
  input  logic              rd_rmw,
  input  logic              rd_ign_err,
  input  logic              rd_from_eng,
  input  logic [SIG_W-1:0]  rd_sig,
  output logic              cpl_valid,
  output logic [DATA_W-1:0] cpl_data,
  output logic              cpl_rmw,
  output logic              cpl_err,
  output logic [SIG_W-1:0]  cpl_sig,
  input  logic              csr_we,
  input  logic [1:0]        csr_sel,
  input  logic [CSR_W-1:0]  csr_wdata,
  output logic [CSR_W-1:0]  csr_rdata,
  output logic              irq,
  output logic              fiq
);
  localparam logic [SIG_W-1:0] SIG_NULL = '0;

  // named internal events for the checker
  logic [CSR_W-1:0]  ctrl_q;
  logic              chk_en;
  logic [LANES-1:0]  bad_lanes;
  logic [LANES-1:0]  clr_mask;
  logic [LANES-1:0]  err_q;
  logic [ADDR_W-1:0] cap_addr;
  logic              cap_evt;
  logic              raise_err;
  reg_sel_e          sel;

  assign sel    = reg_sel_e'(csr_sel);
  assign chk_en = ctrl_q[CTRL_CHK];

  mpg_wr_gen #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .we_q(sram_we), .addr_q(sram_addr),
    .data_q(sram_wdata), .par_q(sram_wpar)
  );

  mpg_rd_chk #(.DATA_W(DATA_W)) u_chk (
    .valid(rd_valid), .chk_en(chk_en), .data(rd_data), .par(rd_par),
    .bad_lanes(bad_lanes)
  );

  assign clr_mask = (csr_we && sel == REG_STAT) ? csr_wdata[LANES-1:0] : '0;

  mpg_err_log #(.LANES(LANES), .ADDR_W(ADDR_W)) u_log (
    .clk(clk), .rst_n(rst_n), .set_lanes(bad_lanes), .set_addr(rd_addr),
    .clr_mask(clr_mask), .err_q(err_q), .addr_q(cap_addr), .cap_evt(cap_evt)
  );

  assign raise_err = (bad_lanes != '0) && !rd_ign_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (csr_we && sel == REG_CTRL) begin
      ctrl_q <= csr_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpl_valid <= 1'b0;
      cpl_err   <= 1'b0;
      cpl_rmw   <= 1'b0;
      cpl_data  <= '0;
      cpl_sig   <= '0;
    end else begin
      cpl_valid <= rd_valid;
      cpl_err   <= rd_valid && raise_err;
      if (rd_valid) begin
        cpl_data <= rd_data;
        cpl_rmw  <= rd_rmw;
        cpl_sig  <= (raise_err && rd_from_eng) ? SIG_NULL : rd_sig;
      end
    end
  end

  assign irq = (err_q != '0) && ctrl_q[CTRL_IRQ];
  assign fiq = (err_q != '0) && ctrl_q[CTRL_FIQ];

  always_comb begin
    unique case (sel)
      REG_CTRL: csr_rdata = ctrl_q;
      REG_STAT: csr_rdata = CSR_W'(err_q);
      REG_ADDR: csr_rdata = CSR_W'(cap_addr);
      default:  csr_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mpg_guard_chk.sv
module mpg_guard_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned SIG_W  = 4,
  parameter int unsigned LANES  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_valid,
  input logic              rd_ign_err,
  input logic              rd_from_eng,
  input logic [SIG_W-1:0]  rd_sig,
  input logic              sram_we,
  input logic [DATA_W-1:0] sram_wdata,
  input logic [LANES-1:0]  sram_wpar,
  input logic              cpl_valid,
  input logic              cpl_err,
  input logic [SIG_W-1:0]  cpl_sig,
  input logic              irq,
  input logic              fiq,
  input logic              chk_en,
  input logic [LANES-1:0]  err_q,
  input logic [LANES-1:0]  clr_mask,
  input logic [ADDR_W-1:0] cap_addr
);
  localparam int unsigned LW = DATA_W / LANES;

  function automatic logic all_even(input logic [DATA_W-1:0] d,
                                    input logic [LANES-1:0] p);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < LANES; i++)
      if (($countones({p[i], d[i*LW +: LW]}) % 2) != 0) ok = 1'b0;
    return ok;
  endfunction

  a_r1_wr_even: assert property (@(posedge clk) disable iff (!rst_n)
    sram_we |-> all_even(sram_wdata, sram_wpar));

  a_r3_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(chk_en) |-> (((err_q & ~$past(err_q)) == '0) && !cpl_err));

  a_r4_flag_logged: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_err |-> (err_q != '0));

  a_r6_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past((err_q & ~clr_mask) != '0) |-> $stable(cap_addr));

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(err_q) & ~$past(clr_mask) & ~err_q) == '0));

  a_r8_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    (irq || fiq) |-> (err_q != '0));

  a_r9_ign_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_valid && rd_ign_err) |-> !cpl_err);

  a_r10_sig_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && !cpl_err) |-> (cpl_sig == $past(rd_sig)));

  a_r10_sig_null: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_err && $past(rd_from_eng)) |-> (cpl_sig == '0));

  a_r11_one_cpl: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> cpl_valid);
endmodule

bind mem_parity_guard mpg_guard_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SIG_W(SIG_W), .LANES(LANES)
) u_guard_chk (
  .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_ign_err(rd_ign_err),
  .rd_from_eng(rd_from_eng), .rd_sig(rd_sig), .sram_we(sram_we),
  .sram_wdata(sram_wdata), .sram_wpar(sram_wpar), .cpl_valid(cpl_valid),
  .cpl_err(cpl_err), .cpl_sig(cpl_sig), .irq(irq), .fiq(fiq),
  .chk_en(chk_en), .err_q(err_q), .clr_mask(clr_mask), .cap_addr(cap_addr)
);

// File: tb/mem_parity_guard_tb.sv
module mem_parity_guard_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [19:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        sram_we;
  logic [19:0] sram_addr;
  logic [31:0] sram_wdata;
  logic [3:0]  sram_wpar;
  logic        rd_valid = 1'b0;
  logic [19:0] rd_addr = '0;
  logic [31:0] rd_data = '0;
  logic [3:0]  rd_par = '0;
  logic        rd_rmw = 1'b0, rd_ign_err = 1'b0, rd_from_eng = 1'b0;
  logic [3:0]  rd_sig = '0;
  logic        cpl_valid, cpl_rmw, cpl_err;
  logic [31:0] cpl_data;
  logic [3:0]  cpl_sig;
  logic        csr_we = 1'b0;
  logic [1:0]  csr_sel = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        irq, fiq;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] m_ctrl = '0;
  logic [3:0]  m_err = '0;
  logic [19:0] m_addr = '0;

  always #(CLK_P/2) clk = ~clk;

  mem_parity_guard u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .sram_we(sram_we), .sram_addr(sram_addr),
    .sram_wdata(sram_wdata), .sram_wpar(sram_wpar), .rd_valid(rd_valid),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_par(rd_par), .rd_rmw(rd_rmw),
    .rd_ign_err(rd_ign_err), .rd_from_eng(rd_from_eng), .rd_sig(rd_sig),
    .cpl_valid(cpl_valid), .cpl_data(cpl_data), .cpl_rmw(cpl_rmw),
    .cpl_err(cpl_err), .cpl_sig(cpl_sig), .csr_we(csr_we),
    .csr_sel(csr_sel), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .irq(irq), .fiq(fiq)
  );

  // even parity per lane, by counting ones bit by bit
  function automatic logic [3:0] ref_par(input logic [31:0] d);
    logic [3:0] p;
    for (int l = 0; l < 4; l++) begin
      int ones = 0;
      for (int b = 0; b < 8; b++) ones += int'(d[l*8 + b]);
      p[l] = (ones % 2 == 1);
    end
    return p;
  endfunction

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic check_state();
    csr_sel = 2'd0; #1;
    check("R7 ctrl readback", csr_rdata, m_ctrl);
    csr_sel = 2'd1; #1;
    check("R7 error bits", csr_rdata, {28'd0, m_err});
    csr_sel = 2'd2; #1;
    check("R6 error address", csr_rdata, {12'd0, m_addr});
    check("R8 irq", {31'd0, irq}, {31'd0, (m_err != 0) && m_ctrl[1]});
    check("R8 fiq", {31'd0, fiq}, {31'd0, (m_err != 0) && m_ctrl[2]});
  endtask

  task automatic csr_write(input logic [1:0] sel, input logic [31:0] v);
    csr_we = 1'b1; csr_sel = sel; csr_wdata = v;
    @(negedge clk);
    csr_we = 1'b0;
    if (sel == 2'd0) m_ctrl = v;
    if (sel == 2'd1) m_err = m_err & ~v[3:0];
    check_state();
  endtask

  task automatic do_write(input logic [19:0] a, input logic [31:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    check("R1 sram_we", {31'd0, sram_we}, 32'd1);
    check("R1 sram_addr", {12'd0, sram_addr}, {12'd0, a});
    check("R1 sram_wdata", sram_wdata, d);
    check(m_ctrl[0] ? "R1 parity" : "R2 parity, checking off",
          {28'd0, sram_wpar}, {28'd0, ref_par(d)});
  endtask

  task automatic do_read(input logic [19:0] a, input logic [31:0] d,
                         input logic [3:0] flips, input logic ign,
                         input logic eng, input logic rmw,
                         input logic [3:0] sig);
    logic [31:0] dd;
    logic [3:0]  bad;
    logic        e_err;
    dd = d;
    for (int l = 0; l < 4; l++)
      if (flips[l]) dd = dd ^ (32'd1 << (l*8 + int'($urandom % 8)));
    rd_valid = 1'b1; rd_addr = a; rd_data = dd; rd_par = ref_par(d);
    rd_ign_err = ign; rd_from_eng = eng; rd_rmw = rmw; rd_sig = sig;
    @(negedge clk);
    rd_valid = 1'b0;
    bad = m_ctrl[0] ? flips : 4'd0;
    if (bad != 0 && m_err == 0) m_addr = a;
    m_err = m_err | bad;
    e_err = (bad != 0) && !ign;
    check("R11 cpl_valid", {31'd0, cpl_valid}, 32'd1);
    check("R11 cpl_data", cpl_data, dd);
    check("R5 cpl_rmw", {31'd0, cpl_rmw}, {31'd0, rmw});
    check(ign ? "R9 cpl_err with ignore" :
          (m_ctrl[0] ? "R4 cpl_err" : "R3 cpl_err, checking off"),
          {31'd0, cpl_err}, {31'd0, e_err});
    check("R10 cpl_sig", {28'd0, cpl_sig},
          {28'd0, (e_err && eng) ? 4'd0 : sig});
    check_state();
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check("R11 cpl_valid after reset", {31'd0, cpl_valid}, 32'd0);
    check("R1 sram_we after reset", {31'd0, sram_we}, 32'd0);
    check_state();

    // write parity, checking off then on (R1, R2)
    do_write(20'h00001, 32'h0000_0000);
    do_write(20'h00002, 32'hFFFF_FFFF);
    do_write(20'h00003, 32'h0102_0304);
    do_write(20'hFFFFF, 32'h8000_0001);
    csr_write(2'd0, 32'h1);
    do_write(20'h00004, 32'h0102_0304);
    csr_write(2'd0, 32'h0);

    // R3: every lane wrong while checking is off
    do_read(20'h00010, 32'hDEAD_BEEF, 4'hF, 1'b0, 1'b1, 1'b0, 4'd5);

    // R4/R6/R8/R10: enable checking and irq
    csr_write(2'd0, 32'h3);
    do_read(20'h00011, 32'h1234_5678, 4'h0, 1'b0, 1'b1, 1'b0, 4'd3);
    do_read(20'h00A0A, 32'hCAFE_F00D, 4'h4, 1'b0, 1'b1, 1'b0, 4'd5);
    do_read(20'h00B0B, 32'h0F0F_0F0F, 4'h1, 1'b0, 1'b1, 1'b0, 4'd6);
    // R7: partial then full clear
    csr_write(2'd1, 32'h4);
    csr_write(2'd1, 32'hF);
    // R9: ignore token suppresses the flag but not the logging
    do_read(20'h00C0C, 32'hAAAA_5555, 4'h2, 1'b1, 1'b1, 1'b0, 4'd7);
    // R10: flagged read from a non-engine requester keeps its signal
    do_read(20'h00D0D, 32'h1111_2222, 4'h8, 1'b0, 1'b0, 1'b0, 4'd9);
    // R5: atomic read phase is checked
    csr_write(2'd1, 32'hF);
    do_read(20'h00E0E, 32'h7777_8888, 4'h8, 1'b0, 1'b1, 1'b1, 4'd2);
    // R8: fast interrupt only
    csr_write(2'd0, 32'h5);

    // random mix
    for (int it = 0; it < 600; it++) begin
      int op;
      op = int'($urandom % 10);
      if (op < 5) begin
        logic [3:0] fl;
        fl = ($urandom % 3 == 0) ? 4'(1 << ($urandom % 4)) :
             (($urandom % 4 == 0) ? 4'($urandom) : 4'd0);
        do_read(20'($urandom), $urandom, fl, 1'($urandom % 4 == 0),
                1'($urandom), 1'($urandom % 5 == 0), 4'($urandom));
      end else if (op < 7) begin
        do_write(20'($urandom), $urandom);
      end else if (op < 9) begin
        csr_write(2'd1, 32'($urandom % 16));
      end else begin
        csr_write(2'd0, 32'($urandom % 8));
      end
    end

    summary();
    $finish;
  end
endmodule